// File: doc/BRIEF.md
# Attempt-Limited Combination Lock Controller

This block is the control core of a digital combination lock. A user sets an 8-bit secret from a bank of switches with a "set" button. The lock then closes and allows a fixed number of guesses, entered on the same switches with a separate "guess" button. A matching guess opens the lock again. Each miss lowers a visible remaining-tries count. When the count runs out, the lock enters a lockout state that only reset clears.

The block expects single-cycle, already-debounced button pulses. It drives one open indicator and a binary remaining-tries value, which a separate display decoder can show. The switch value matters only in the cycle a button pulses. If the user sets a new secret during the guessing phase, the new secret is stored and the full allowance of tries is restored.

Top module: `combo_lock_ctrl`

## Requirements
- R1: After reset, `lock_open` is 1 and `tries_left` is 0. Whenever `lock_open` is 1, `tries_left` reads 0.
- R2: When the lock is open, a `set_pulse` stores `code_sw` as the secret. On the next cycle `lock_open` is 0 and `tries_left` equals ATTEMPTS (3).
- R3: When the lock is closed and not in lockout, a `guess_pulse` whose `code_sw` equals the stored secret sets `lock_open` to 1 and `tries_left` to 0 on the next cycle.
- R4: When the lock is closed and `tries_left` is above 1, a wrong guess lowers `tries_left` by exactly one on the next cycle, and the lock stays closed.
- R5: A wrong guess with `tries_left` equal to 1 enters lockout: `tries_left` is 0 and `lock_open` is 0. After that, guess pulses (even correct ones) and set pulses have no effect until reset.
- R6: A `set_pulse` while guessing stores the new switch value and restores `tries_left` to ATTEMPTS. After that, the previous secret counts as a wrong guess.
- R7: If `set_pulse` and `guess_pulse` are both high in one cycle, only the set action takes place. The tries count is not lowered and the lock does not open.
- R8: A `guess_pulse` while the lock is open has no effect: `lock_open` stays 1 and `tries_left` stays 0.
- R9: `code_sw` is sampled only in a cycle with a button pulse. Changing the switches in other cycles changes neither output nor the stored secret.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sw | input | CODE_W (8) | Switch value used as the secret or as a guess |
| set_pulse | input | 1 | One-cycle pulse that stores a new secret |
| guess_pulse | input | 1 | One-cycle pulse that submits a guess |
| lock_open | output | 1 | 1 while the lock is open |
| tries_left | output | CNT_W (4) | Binary count of guesses remaining; 0 when open or locked out |

## Verification
The bench instantiates the block with its defaults: an 8-bit code, three attempts and a 4-bit count. With a 256-value code space, a random guess stream that often reuses the reference model's current secret reaches hits, misses, lockout and re-keying many times in a short run. With only three attempts, a lockout takes only a few cycles to reach. Directed sequences target set-over-guess priority, guesses while open, switch changes between pulses, and the old secret after re-keying.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN    = 2'd0,
    MODE_ARMED   = 2'd1,
    MODE_BLOCKED = 2'd2
  } lock_mode_e;
endpackage

// File: rtl/lock_code_reg.sv
module lock_code_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] sw_i,
  output logic              match_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] bit_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else if (load_i) code_q <= sw_i;
  end

  for (genvar i = 0; i < CODE_W; i++) begin : g_eq
    assign bit_eq[i] = ~(code_q[i] ^ sw_i[i]);
  end

  assign match_o = &bit_eq;

  assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_q));
  assert_code_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> code_q == $past(sw_i));
endmodule

// File: rtl/lock_try_counter.sv
module lock_try_counter #(
  parameter int ATTEMPTS = 3,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic             miss_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] left_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ATTEMPTS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (reload_i) left_q <= FULL;
    else if (hit_i) left_q <= '0;
    else if (miss_i && left_q != '0) left_q <= left_q - ONE;
  end

  assign left_o = left_q;
  assign last_o = (left_q == ONE);

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= FULL);
  assert_miss_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_i && !reload_i && !hit_i && left_q != '0) |=> left_q == $past(left_q) - ONE);
  assert_reload_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> left_q == FULL);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic       guess_i,
  input  logic       match_i,
  input  logic       last_i,
  output lock_mode_e mode_o,
  output logic       store_o,
  output logic       hit_o,
  output logic       miss_o
);
  lock_mode_e mode_q, mode_d;
  logic       guess_ev;

  assign store_o  = set_i && (mode_q != MODE_BLOCKED);
  assign guess_ev = guess_i && !set_i && (mode_q == MODE_ARMED);
  assign hit_o    = guess_ev && match_i;
  assign miss_o   = guess_ev && !match_i;

  always_comb begin
    mode_d = mode_q;
    if (store_o) mode_d = MODE_ARMED;
    else if (hit_o) mode_d = MODE_OPEN;
    else if (miss_o && last_i) mode_d = MODE_BLOCKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OPEN;
    else mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_lockout_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_BLOCKED |=> mode_q == MODE_BLOCKED);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && mode_q != MODE_BLOCKED) |=> mode_q == MODE_ARMED);
  assert_hit_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (guess_i && !set_i && match_i && mode_q == MODE_ARMED) |=> mode_q == MODE_OPEN);
  assert_open_ignores_guess_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OPEN && !set_i) |=> mode_q == MODE_OPEN);
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import lock_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int ATTEMPTS = 3,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_sw,
  input  logic              set_pulse,
  input  logic              guess_pulse,
  output logic              lock_open,
  output logic [CNT_W-1:0]  tries_left
);
  lock_mode_e mode;
  logic       store, hit, miss, match, last;

  lock_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_pulse),
    .guess_i (guess_pulse),
    .match_i (match),
    .last_i  (last),
    .mode_o  (mode),
    .store_o (store),
    .hit_o   (hit),
    .miss_o  (miss)
  );

  lock_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (store),
    .sw_i    (code_sw),
    .match_o (match)
  );

  lock_try_counter #(.ATTEMPTS(ATTEMPTS), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (store),
    .miss_i   (miss),
    .hit_i    (hit),
    .left_o   (tries_left),
    .last_o   (last)
  );

  assign lock_open = (mode == MODE_OPEN);

  assert_open_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lock_open |-> tries_left == '0);
  assert_closed_has_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_open && tries_left == '0) |=> (!lock_open && tries_left == '0));
endmodule

// File: tb/combo_lock_ctrl_tb.sv
`timescale 1ns/1ps
module combo_lock_ctrl_tb;
  localparam int CW = 8;
  localparam int NA = 3;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] code_sw = '0;
  logic          set_pulse = 1'b0;
  logic          guess_pulse = 1'b0;
  logic          lock_open;
  logic [NC-1:0] tries_left;

  int    vectors = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model: 0 open, 1 guessing, 2 lockout
  int m_mode = 0;
  int m_left = 0;
  int m_code = 0;

  always #2.5 clk = ~clk;

  combo_lock_ctrl #(.CODE_W(CW), .ATTEMPTS(NA), .CNT_W(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .code_sw(code_sw),
    .set_pulse(set_pulse), .guess_pulse(guess_pulse),
    .lock_open(lock_open), .tries_left(tries_left)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_code = 0;
    end else if (set_pulse && m_mode != 2) begin
      m_code = int'(code_sw); m_mode = 1; m_left = NA;
    end else if (guess_pulse && m_mode == 1) begin
      if (int'(code_sw) == m_code) begin m_mode = 0; m_left = 0; end
      else if (m_left == 1) begin m_mode = 2; m_left = 0; end
      else m_left = m_left - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (lock_open !== (m_mode == 0) || int'(tries_left) != m_left) begin
        errors++;
        $display("FAIL %s model: open=%0b left=%0d expected open=%0b left=%0d",
                 cur_req, lock_open, tries_left, (m_mode == 0), m_left);
      end
    end
  end

  task automatic step(input bit s, input bit g, input logic [CW-1:0] v);
    @(negedge clk);
    set_pulse = s; guess_pulse = g; code_sw = v;
  endtask

  task automatic idle();
    @(negedge clk);
    set_pulse = 1'b0; guess_pulse = 1'b0;
  endtask

  task automatic check(input string req, input bit exp_open, input int exp_left);
    vectors++;
    if (lock_open !== exp_open || int'(tries_left) != exp_left) begin
      errors++;
      $display("FAIL %s: open=%0b left=%0d expected open=%0b left=%0d",
               req, lock_open, tries_left, exp_open, exp_left);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    set_pulse = 1'b0; guess_pulse = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: open=%0b left=%0d expected run to finish", lock_open, tries_left);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle();
    cur_req = "R1"; check("R1 reset", 1'b1, 0);

    cur_req = "R8"; step(0, 1, 8'h00); idle(); check("R8 guess while open", 1'b1, 0);

    cur_req = "R2"; step(1, 0, 8'hA5); idle(); check("R2 set closes", 1'b0, NA);

    cur_req = "R9";
    step(0, 0, 8'h5A); step(0, 0, 8'hFF); idle(); check("R9 switches idle", 1'b0, NA);
    cur_req = "R3"; step(0, 1, 8'hA5); idle(); check("R3 correct guess", 1'b1, 0);

    cur_req = "R4"; step(1, 0, 8'h3C); idle();
    step(0, 1, 8'h3D); idle(); check("R4 first miss", 1'b0, 2);
    step(0, 1, 8'h00); idle(); check("R4 second miss", 1'b0, 1);

    cur_req = "R6"; step(1, 0, 8'h77); idle(); check("R6 rekey restores", 1'b0, NA);
    step(0, 1, 8'h3C); idle(); check("R6 old code misses", 1'b0, 2);
    cur_req = "R3"; step(0, 1, 8'h77); idle(); check("R3 new code opens", 1'b1, 0);

    cur_req = "R5"; step(1, 0, 8'h11); idle();
    step(0, 1, 8'h12); idle(); step(0, 1, 8'h13); idle(); step(0, 1, 8'h14); idle();
    check("R5 lockout", 1'b0, 0);
    step(0, 1, 8'h11); idle(); check("R5 correct ignored", 1'b0, 0);
    step(1, 0, 8'h22); idle(); check("R5 set ignored", 1'b0, 0);
    step(1, 1, 8'h22); idle(); check("R5 both ignored", 1'b0, 0);
    do_reset(); idle(); check("R1 reset leaves lockout", 1'b1, 0);

    cur_req = "R7"; step(1, 1, 8'h99); idle(); check("R7 both while open", 1'b0, NA);
    step(0, 1, 8'h98); idle(); check("R7 miss after", 1'b0, 2);
    step(1, 1, 8'h42); idle(); check("R7 both while guessing", 1'b0, NA);
    step(0, 1, 8'h99); idle(); check("R7 previous code misses", 1'b0, 2);
    step(0, 1, 8'h42); idle(); check("R7 stored switch opens", 1'b1, 0);

    cur_req = "R4"; step(1, 0, 8'h80); idle();
    for (int k = 0; k < 2; k++) begin
      step(0, 1, 8'(k + 1)); idle();
      check("R4 sweep miss", 1'b0, NA - 1 - k);
    end

    cur_req = "R9";
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [CW-1:0] v;
      r = int'($urandom_range(0, 99));
      v = (r < 35) ? CW'(m_code) : CW'($urandom_range(0, 255));
      if (r < 3) do_reset();
      else if (r < 15) step(1, ($urandom_range(0, 3) == 0), v);
      else if (r < 55) step(0, 1, v);
      else step(0, 0, CW'($urandom_range(0, 255)));
    end
    idle(); idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule